// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Writes

A synchronous single-port memory with a command interface that accepts one command on every clock edge and needs no idle cycle between a read and a write. Each command either loads a new external address with a read or a write, or advances the current burst to its next beat. A burst spans four beats inside one aligned group of four words. Only the two low address bits change across the beats, in either an XOR-interleaved or a modulo-4 linear order chosen by a static order input.

Writes carry one active-low enable per byte lane, so any subset of lanes can be written in a cycle. A write whose enables are all high leaves memory unchanged. Read data is registered and appears two edges after the read command was taken. Write data is sampled at the edge two edges after the write command, so reads and writes use the memory at the same pipeline depth. A read issued right after a write to the same word therefore sees the new bytes without any extra forwarding path.

Top module: `sram_pipe_burst`

## Requirements
- R1: A read command registered at edge E makes `rd_valid` high after edge E+2, with `rdata` holding the word at the issued address. `rd_valid` is low after every edge whose committing command is not a read.
- R2: A write command registered at edge E samples `wdata` at edge E+2. Lane `l` (bits `l*LANE_W +: LANE_W`) is written only when `bwe_n[l]` is 0 in the command's cycle, and any combination of lanes may be written.
- R3: A write command with `bwe_n` all ones changes no memory bit.
- R4: During a read command `bwe_n` has no effect, and no memory lane is written.
- R5: With `burst_ilv` = 1, beat k (k = 0..3) of a burst uses low address bits equal to the start low bits XOR k. The upper address bits stay those of the loading command.
- R6: With `burst_ilv` = 0, beat k uses low bits equal to (start low bits + k) mod 4, with the upper bits unchanged.
- R7: `adv` = 0 loads `addr` and takes the read or write type from `rw_n` (1 = read, 0 = write). `adv` = 1 ignores `addr` and `rw_n` and repeats the type of the loading command. `bwe_n` is taken from the advancing cycle.
- R8: Reads and writes may alternate on consecutive cycles. A read issued on the cycle after a write to the same word returns the bytes that write stored.
- R9: An active-low reset `rst_n` clears the pipeline (`rd_valid` = 0) and sets the burst state to a read of word 0 at beat 0. Memory contents are kept across reset.
- R10: An advance after the fourth beat wraps to beat 0 of the same group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| adv | input | 1 | 1 advance burst, 0 load new address |
| rw_n | input | 1 | On load: 1 read, 0 write |
| addr | input | ADDR_W | Word address on load |
| bwe_n | input | LANES | Active-low byte-lane write enables |
| wdata | input | DATA_W | Write data, sampled two edges after the write command |
| rdata | output | DATA_W | Registered read data |
| rd_valid | output | 1 | rdata holds the result of a read |

## Verification
A write commit and a read of the same word can fall on adjacent edges, and a burst advance can coincide with one of those commits. The bench provokes both with write-then-read pairs to one word, with alternating write/read streams, and with write bursts followed at once by read bursts over the same group. A behavioural model keeps its own memory, burst counter and two-slot command queue. On every clock it predicts whether read data is due and what value it holds, and it compares that prediction against `rd_valid` and `rdata`.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  // Low two address bits of beat 'beat' for a burst starting at 'start'.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input burst_order_e order);
    beat_low = (order == ORDER_XOR) ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/sram_burst_gen.sv
module sram_burst_gen
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              rw_n,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] iss_addr,
  output logic              iss_wr
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic              wr_q, wr_d;
  burst_order_e      order;

  assign order = ilv ? ORDER_XOR : ORDER_LINEAR;

  always_comb begin
    if (adv) begin
      base_d = base_q;
      beat_d = beat_q + 2'd1;
      wr_d   = wr_q;
    end else begin
      base_d = addr;
      beat_d = 2'd0;
      wr_d   = ~rw_n;
    end
  end

  assign iss_addr = {base_d[ADDR_W-1:2], beat_low(base_d[1:0], beat_d, order)};
  assign iss_wr   = wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
      wr_q   <= wr_d;
    end
  end

endmodule

// File: rtl/sram_cmd_pipe.sv
module sram_cmd_pipe #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_wr,
  input  logic [LANES-1:0]  in_bwe_n,
  output logic              out_vld,
  output logic              out_wr,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_bwe_n
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0]             vld_q;
  logic [STAGES-1:0]             wr_q;
  logic [STAGES-1:0][ADDR_W-1:0] addr_q;
  logic [STAGES-1:0][LANES-1:0]  bwe_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic              vld_d;
    logic              wr_d;
    logic [ADDR_W-1:0] addr_d;
    logic [LANES-1:0]  bwe_d;

    if (g == 0) begin : g_head
      always_comb begin
        vld_d  = 1'b1;
        wr_d   = in_wr;
        addr_d = in_addr;
        bwe_d  = in_bwe_n;
      end
    end else begin : g_body
      always_comb begin
        vld_d  = vld_q[g-1];
        wr_d   = wr_q[g-1];
        addr_d = addr_q[g-1];
        bwe_d  = bwe_q[g-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        wr_q[g]   <= 1'b0;
        addr_q[g] <= '0;
        bwe_q[g]  <= '1;
      end else begin
        vld_q[g]  <= vld_d;
        wr_q[g]   <= wr_d;
        addr_q[g] <= addr_d;
        bwe_q[g]  <= bwe_d;
      end
    end
  end

  assign out_vld   = vld_q[LAST];
  assign out_wr    = wr_q[LAST];
  assign out_addr  = addr_q[LAST];
  assign out_bwe_n = bwe_q[LAST];

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic [$clog2(DEPTH)-1:0] acc_addr,
  input  logic [LANES-1:0]         lane_we,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);

  localparam int LANE_W = DATA_W / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[l]) store[acc_addr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = store[acc_addr];
  end

endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 36,
  parameter int LANES  = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_ilv,
  input  logic              adv,
  input  logic              rw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bwe_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);

  logic [ADDR_W-1:0] iss_addr;
  logic              iss_wr;
  logic              c_vld, c_wr;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_bwe_n;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] arr_rdata;
  logic              rd_fire;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_valid_q;

  sram_burst_gen #(.ADDR_W(ADDR_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .rw_n     (rw_n),
    .ilv      (burst_ilv),
    .addr     (addr),
    .iss_addr (iss_addr),
    .iss_wr   (iss_wr)
  );

  sram_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(2)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_addr   (iss_addr),
    .in_wr     (iss_wr),
    .in_bwe_n  (bwe_n),
    .out_vld   (c_vld),
    .out_wr    (c_wr),
    .out_addr  (c_addr),
    .out_bwe_n (c_bwe_n)
  );

  always_comb begin
    lane_we = '0;
    if (c_vld && c_wr) lane_we = ~c_bwe_n;
    rd_fire = c_vld && !c_wr;
  end

  sram_lane_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LANES(LANES)) u_arr (
    .clk      (clk),
    .acc_addr (c_addr),
    .lane_we  (lane_we),
    .wdata    (wdata),
    .rdata    (arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      rd_valid_q <= rd_fire;
      if (rd_fire) rdata_q <= arr_rdata;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/sram_pipe_burst_chk.sv
module sram_pipe_burst_chk #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic              rw_n,
  input logic              burst_ilv,
  input logic [LANES-1:0]  bwe_n,
  input logic [ADDR_W-1:0] iss_addr,
  input logic [LANES-1:0]  lane_we,
  input logic              rd_valid
);

  logic             trk_wr;
  logic             cur_wr;
  logic             rd_d1, rd_d2, rd_d3;
  logic             wr_d1, wr_d2;
  logic [LANES-1:0] mk_d1, mk_d2;
  logic [ADDR_W-1:0] prev_addr;

  assign cur_wr = adv ? trk_wr : ~rw_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_wr    <= 1'b0;
      rd_d1     <= 1'b0;
      rd_d2     <= 1'b0;
      rd_d3     <= 1'b0;
      wr_d1     <= 1'b0;
      wr_d2     <= 1'b0;
      mk_d1     <= '1;
      mk_d2     <= '1;
      prev_addr <= '0;
    end else begin
      trk_wr    <= cur_wr;
      rd_d1     <= !cur_wr;
      rd_d2     <= rd_d1;
      rd_d3     <= rd_d2;
      wr_d1     <= cur_wr;
      wr_d2     <= wr_d1;
      mk_d1     <= bwe_n;
      mk_d2     <= mk_d1;
      prev_addr <= iss_addr;
    end
  end

  p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == rd_d3);

  p_we_only_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> wr_d2);

  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_d2 && (&mk_d2)) |-> (lane_we == '0));

  p_read_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_d2 |-> (lane_we == '0));

  p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (iss_addr[ADDR_W-1:2] == prev_addr[ADDR_W-1:2]));

  p_xor_bit0_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && burst_ilv) |-> (iss_addr[0] != prev_addr[0]));

  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !burst_ilv) |-> (iss_addr[1:0] == prev_addr[1:0] + 2'd1));

endmodule

bind sram_pipe_burst sram_pipe_burst_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adv       (adv),
  .rw_n      (rw_n),
  .burst_ilv (burst_ilv),
  .bwe_n     (bwe_n),
  .iss_addr  (iss_addr),
  .lane_we   (lane_we),
  .rd_valid  (rd_valid)
);

// File: tb/tb_sram_pipe_burst.sv
module tb_sram_pipe_burst;

  localparam int DEPTH  = 256;
  localparam int DATA_W = 36;
  localparam int LANES  = 4;
  localparam int AW     = $clog2(DEPTH);
  localparam int LW     = DATA_W / LANES;

  logic              clk;
  logic              rst_n;
  logic              burst_ilv;
  logic              adv;
  logic              rw_n;
  logic [AW-1:0]     addr;
  logic [LANES-1:0]  bwe_n;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              rd_valid;

  int checks;
  int failures;

  sram_pipe_burst #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .burst_ilv(burst_ilv), .adv(adv), .rw_n(rw_n),
    .addr(addr), .bwe_n(bwe_n), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model state
  logic [DATA_W-1:0] ref_mem [DEPTH];
  int                m_base, m_beat;
  bit                m_wr;
  bit                q_vld [2];
  bit                q_wr  [2];
  int                q_addr[2];
  logic [LANES-1:0]  q_mask[2];
  string             q_tag [2];
  bit                exp_valid;
  logic [DATA_W-1:0] exp_data;
  string             exp_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_base = 0; m_beat = 0; m_wr = 0;
    for (int i = 0; i < 2; i++) begin
      q_vld[i] = 0; q_wr[i] = 0; q_addr[i] = 0; q_mask[i] = '1; q_tag[i] = "R9";
    end
    exp_valid = 0;
  endtask

  task automatic compare();
    check(rd_valid === exp_valid, exp_tag, "rd_valid", DATA_W'(rd_valid), DATA_W'(exp_valid));
    if (exp_valid)
      check(rdata === exp_data, exp_tag, "rdata", rdata, exp_data);
  endtask

  // One clock: called just after a falling edge; ends just after the next one.
  task automatic cyc(input bit ilv, input bit a, input bit rn, input int ad,
                     input logic [LANES-1:0] mk, input string tag);
    logic [DATA_W-1:0] wd;
    int low, iaddr;
    wd = {$urandom, $urandom};
    burst_ilv = ilv; adv = a; rw_n = rn; addr = AW'(ad); bwe_n = mk; wdata = wd;
    @(posedge clk);
    // commit stage
    exp_valid = 0;
    exp_tag = q_tag[1];
    if (q_vld[1] && q_wr[1]) begin
      for (int l = 0; l < LANES; l++)
        if (!q_mask[1][l]) ref_mem[q_addr[1]][l*LW +: LW] = wd[l*LW +: LW];
    end else if (q_vld[1]) begin
      exp_valid = 1;
      exp_data = ref_mem[q_addr[1]];
    end
    q_vld[1] = q_vld[0]; q_wr[1] = q_wr[0]; q_addr[1] = q_addr[0];
    q_mask[1] = q_mask[0]; q_tag[1] = q_tag[0];
    // burst model
    if (!a) begin m_base = ad; m_beat = 0; m_wr = !rn; end
    else m_beat = (m_beat + 1) % 4;
    low = ilv ? ((m_base % 4) ^ m_beat) : (((m_base % 4) + m_beat) % 4);
    iaddr = (m_base / 4) * 4 + low;
    q_vld[0] = 1; q_wr[0] = m_wr; q_addr[0] = iaddr; q_mask[0] = mk; q_tag[0] = tag;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    adv = 1'b0; rw_n = 1'b1; addr = '0; bwe_n = '1; wdata = '0; burst_ilv = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    check(rd_valid === 1'b0, "R9", "rd_valid in reset", DATA_W'(rd_valid), '0);
    rst_n = 1'b1;
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, 0, 4'hF, tag);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    exp_tag = "R9";
    @(negedge clk);
    do_reset();
    // Fill words 0..63 with full writes
    for (int a = 0; a < 64; a++) cyc(1'b1, 1'b0, 1'b0, a, 4'h0, "R2");
    flush("R1");
    // R1 / R4: reads with arbitrary lane enables
    for (int a = 0; a < 12; a++) cyc(1'b1, 1'b0, 1'b1, (a * 5) % 64, LANES'(a), "R4");
    flush("R1");
    // R2: partial lane writes, then read back
    cyc(1'b0, 1'b0, 1'b0, 10, 4'b1110, "R2");
    cyc(1'b0, 1'b0, 1'b0, 11, 4'b0101, "R2");
    cyc(1'b0, 1'b0, 1'b0, 12, 4'b1001, "R2");
    cyc(1'b0, 1'b0, 1'b1, 10, 4'h0, "R2");
    cyc(1'b0, 1'b0, 1'b1, 11, 4'h0, "R2");
    cyc(1'b0, 1'b0, 1'b1, 12, 4'h0, "R2");
    // R3: all-high mask leaves the word alone
    cyc(1'b0, 1'b0, 1'b0, 20, 4'hF, "R3");
    cyc(1'b0, 1'b0, 1'b1, 20, 4'h0, "R3");
    flush("R3");
    // R8: write then read of the same word, and alternating streams
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 30 + i, LANES'(i + 3), "R8");
      cyc(1'b1, 1'b0, 1'b1, 30 + i, 4'hF, "R8");
    end
    flush("R8");
    // R5/R10: interleaved read burst from low bits 10, six beats
    cyc(1'b1, 1'b0, 1'b1, 6, 4'hF, "R5");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b0, 63, 4'h0, "R5");
    for (int k = 0; k < 2; k++) cyc(1'b1, 1'b1, 1'b0, 63, 4'h0, "R10");
    // R6/R10: linear read burst from low bits 01
    cyc(1'b0, 1'b0, 1'b1, 41, 4'hF, "R6");
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0, 0, 4'h0, "R6");
    cyc(1'b0, 1'b1, 1'b1, 0, 4'h0, "R10");
    // R7: write burst by advances with per-beat lanes, then read bursts back
    cyc(1'b1, 1'b0, 1'b0, 51, 4'b0000, "R7");
    cyc(1'b1, 1'b1, 1'b1, 7, 4'b1010, "R7");
    cyc(1'b1, 1'b1, 1'b1, 7, 4'b0110, "R7");
    cyc(1'b1, 1'b1, 1'b1, 7, 4'b1111, "R7");
    cyc(1'b0, 1'b0, 1'b1, 48, 4'hF, "R7");
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0, 0, 4'h0, "R7");
    cyc(1'b0, 1'b0, 1'b0, 18, 4'b0011, "R7");
    cyc(1'b0, 1'b1, 1'b1, 0, 4'b1100, "R7");
    cyc(1'b1, 1'b0, 1'b1, 18, 4'hF, "R7");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b0, 0, 4'h0, "R7");
    flush("R7");
    // R9: reset mid-run, advance from cleared burst state, memory kept
    cyc(1'b1, 1'b0, 1'b1, 2, 4'hF, "R9");
    do_reset();
    cyc(1'b1, 1'b1, 1'b0, 33, 4'h0, "R9");
    cyc(1'b1, 1'b0, 1'b1, 11, 4'hF, "R9");
    cyc(1'b1, 1'b0, 1'b1, 31, 4'hF, "R9");
    flush("R9");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule